// File: doc/BRIEF.md
# Selector-Based Ternary Full Adder

This block adds two base-3 digits and a binary carry-in. It returns one base-3 sum digit and a binary carry-out. Each digit travels on a 2-bit binary code. The adder does not perform a binary addition. It first decodes operand A into two threshold flags. From those flags it builds A advanced by one step and by two steps around the modulo-3 cycle. The sum is then one of the three rotations of A, and operand B chooses which one.

Two candidate sums and two candidate carries are built side by side, one pair for each value the carry-in can take. A last 2-way choice on the carry-in picks the result. Code 11 is not a legal digit. The block flags it and forces the results to zero.

The block is purely combinational. Several instances can be chained into a carry-propagate adder: the carry-out of one digit goes to the carry-in of the next.

Top module: `tfa_mux_adder`

## Requirements
- R1: A digit is coded on 2 bits as 00 = 0, 01 = 1 and 10 = 2. The sum uses the same code. Carry-in and carry-out are single bits with value 0 or 1.
- R2: For every legal a_i, b_i and cin_i, a_i + b_i + cin_i equals 3 * cout_o + sum_o.
- R3: With cin_i = 0, sum_o follows b_i: b_i = 0 gives a_i, b_i = 1 gives (a_i + 1) mod 3, and b_i = 2 gives (a_i + 2) mod 3.
- R4: With cin_i = 1, sum_o follows b_i: b_i = 0 gives (a_i + 1) mod 3, b_i = 1 gives (a_i + 2) mod 3, and b_i = 2 gives a_i.
- R5: With cin_i = 0, cout_o follows b_i: b_i = 0 gives 0, b_i = 1 gives (a_i == 2), and b_i = 2 gives (a_i > 0).
- R6: With cin_i = 1, cout_o follows b_i: b_i = 0 gives (a_i == 2), b_i = 1 gives (a_i > 0), and b_i = 2 gives 1.
- R7: invalid_o is 1 exactly when a_i or b_i carries code 11.
- R8: While invalid_o is 1, sum_o is 00 and cout_o is 0, whatever cin_i is.
- R9: sum_o never shows code 11.
- R10: The outputs hold no state. They follow the present inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 2 | First digit operand; threshold-decoded and rotated |
| b_i | input | 2 | Second digit operand; drives the 3-way choices |
| cin_i | input | 1 | Binary carry-in; drives the final 2-way choice |
| sum_o | output | 2 | Sum digit |
| cout_o | output | 1 | Binary carry-out |
| invalid_o | output | 1 | High when either operand uses code 11 |

## Verification
Every result is due zero cycles after its stimulus, because no register lies between a port and an output. The driver applies each operand pair on a rising clock edge and queues the expected sum, carry and flag. The monitor compares them on the following falling edge, so the outputs have had half a period to settle. No later edge can separate stimulus from result. The sweep covers all 32 codes, the illegal ones included.

// File: rtl/tfa_pkg.sv
package tfa_pkg;
  localparam int TRIT_W = 2;
  localparam int RADIX  = 3;
  typedef logic [TRIT_W-1:0] trit_t;
  localparam trit_t TRIT_ZERO = 2'd0;
  localparam trit_t TRIT_ONE  = 2'd1;
  localparam trit_t TRIT_TWO  = 2'd2;
  localparam trit_t TRIT_BAD  = 2'd3;
endpackage

// File: rtl/tfa_thresh.sv
module tfa_thresh
  import tfa_pkg::*;
(
  input  trit_t digit_i,
  output logic  lt1_o,
  output logic  lt2_o,
  output logic  bad_o
);
  assign lt1_o = (digit_i == TRIT_ZERO);
  assign lt2_o = ~digit_i[1];
  assign bad_o = (digit_i == TRIT_BAD);

  always_comb begin
    if (!bad_o) begin
      // R1
      thr_onehot_chk: assert ($onehot({~lt2_o, ~lt1_o & lt2_o, lt1_o}))
        else $error("threshold lines not one-hot for digit %0d", digit_i);
      // R1
      thr_order_chk: assert (!lt1_o || lt2_o)
        else $error("threshold flags out of order");
    end
  end
endmodule

// File: rtl/tfa_rotate.sv
module tfa_rotate
  import tfa_pkg::*;
(
  input  logic  lt1_i,
  input  logic  lt2_i,
  output trit_t inc1_o,
  output trit_t inc2_o
);
  always_comb begin
    if (lt1_i)      inc1_o = TRIT_ONE;
    else if (lt2_i) inc1_o = TRIT_TWO;
    else            inc1_o = TRIT_ZERO;
    if (lt1_i)      inc2_o = TRIT_TWO;
    else if (lt2_i) inc2_o = TRIT_ZERO;
    else            inc2_o = TRIT_ONE;
  end

  always_comb begin
    // R9
    rot_legal_chk: assert (inc1_o != TRIT_BAD && inc2_o != TRIT_BAD && inc1_o != inc2_o)
      else $error("rotation produced %0d/%0d", inc1_o, inc2_o);
  end
endmodule

// File: rtl/tfa_sel3.sv
module tfa_sel3
  import tfa_pkg::*;
#(
  parameter int W = 1
) (
  input  trit_t        sel_i,
  input  logic [W-1:0] d0_i,
  input  logic [W-1:0] d1_i,
  input  logic [W-1:0] d2_i,
  output logic [W-1:0] q_o
);
  always_comb begin
    case (sel_i)
      TRIT_ZERO: q_o = d0_i;
      TRIT_ONE:  q_o = d1_i;
      TRIT_TWO:  q_o = d2_i;
      default:   q_o = '0;
    endcase
  end
endmodule

// File: rtl/tfa_mux_adder.sv
module tfa_mux_adder
  import tfa_pkg::*;
(
  input  logic [1:0] a_i,
  input  logic [1:0] b_i,
  input  logic       cin_i,
  output logic [1:0] sum_o,
  output logic       cout_o,
  output logic       invalid_o
);
  localparam int NCIN = 2;

  logic  a_lt1, a_lt2, a_bad, b_bad;
  trit_t a_inc1, a_inc2;
  trit_t rot [RADIX];
  logic [RADIX:0] cy_tab;
  trit_t sum_cand [NCIN];
  logic  cy_cand  [NCIN];
  trit_t sum_pick;
  logic  cy_pick;

  tfa_thresh u_thr_a (
    .digit_i(a_i),
    .lt1_o  (a_lt1),
    .lt2_o  (a_lt2),
    .bad_o  (a_bad)
  );

  tfa_rotate u_rot (
    .lt1_i (a_lt1),
    .lt2_i (a_lt2),
    .inc1_o(a_inc1),
    .inc2_o(a_inc2)
  );

  assign b_bad  = (b_i == TRIT_BAD);
  assign rot[0] = a_i;
  assign rot[1] = a_inc1;
  assign rot[2] = a_inc2;
  // carry entries: never, A==2, A>0, always
  assign cy_tab = {1'b1, ~a_lt1, ~a_lt2, 1'b0};

  for (genvar c = 0; c < NCIN; c++) begin : g_cin
    tfa_sel3 #(.W(TRIT_W)) u_sum (
      .sel_i(b_i),
      .d0_i (rot[(0 + c) % RADIX]),
      .d1_i (rot[(1 + c) % RADIX]),
      .d2_i (rot[(2 + c) % RADIX]),
      .q_o  (sum_cand[c])
    );
    tfa_sel3 #(.W(1)) u_cy (
      .sel_i(b_i),
      .d0_i (cy_tab[0 + c]),
      .d1_i (cy_tab[1 + c]),
      .d2_i (cy_tab[2 + c]),
      .q_o  (cy_cand[c])
    );
  end

  assign sum_pick  = cin_i ? sum_cand[1] : sum_cand[0];
  assign cy_pick   = cin_i ? cy_cand[1]  : cy_cand[0];
  assign invalid_o = a_bad | b_bad;
  assign sum_o     = invalid_o ? TRIT_ZERO : sum_pick;
  assign cout_o    = invalid_o ? 1'b0 : cy_pick;

  // one-hot reference path
  logic [2:0] ref_a, ref_b, ref_s0, ref_s;
  trit_t      ref_sum;
  always_comb begin
    ref_a  = {a_i == TRIT_TWO, a_i == TRIT_ONE, a_i == TRIT_ZERO};
    ref_b  = {b_i == TRIT_TWO, b_i == TRIT_ONE, b_i == TRIT_ZERO};
    ref_s0[0] = (ref_a[0] & ref_b[0]) | (ref_a[1] & ref_b[2]) | (ref_a[2] & ref_b[1]);
    ref_s0[1] = (ref_a[0] & ref_b[1]) | (ref_a[1] & ref_b[0]) | (ref_a[2] & ref_b[2]);
    ref_s0[2] = (ref_a[0] & ref_b[2]) | (ref_a[1] & ref_b[1]) | (ref_a[2] & ref_b[0]);
    ref_s  = cin_i ? {ref_s0[1], ref_s0[0], ref_s0[2]} : ref_s0;
    ref_sum = ref_s[2] ? TRIT_TWO : (ref_s[1] ? TRIT_ONE : TRIT_ZERO);
  end

  always_comb begin
    if (!invalid_o) begin
      // R3 R4
      ref_sum_chk: assert (sum_o == ref_sum)
        else $error("selector sum %0d vs one-hot sum %0d", sum_o, ref_sum);
      // R2
      arith_chk: assert (int'(a_i) + int'(b_i) + int'(cin_i) == 3 * int'(cout_o) + int'(sum_o))
        else $error("digit identity broken");
    end else begin
      // R8
      inv_zero_chk: assert (sum_o == TRIT_ZERO && !cout_o)
        else $error("outputs not cleared on illegal code");
    end
    // R7
    inv_code_chk: assert (invalid_o == ((a_i == TRIT_BAD) || (b_i == TRIT_BAD)))
      else $error("invalid flag mismatch");
  end
endmodule

// File: tb/tfa_mux_adder_tb.sv
module tfa_mux_adder_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [1:0] a, b, sum;
  logic cin, cout, inv;

  tfa_mux_adder u_dut (
    .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum), .cout_o(cout), .invalid_o(inv)
  );

  typedef struct packed {
    logic [1:0] a;
    logic [1:0] b;
    logic       cin;
    logic [1:0] sum;
    logic       cout;
    logic       inv;
  } item_t;

  item_t exp_q [$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R1 R3 R4 R5 R6: expected values from the arithmetic definition
  task automatic drive(input logic [1:0] ta, input logic [1:0] tb, input logic tc);
    item_t it;
    int total;
    @(posedge clk);
    a = ta; b = tb; cin = tc;
    it.a = ta; it.b = tb; it.cin = tc;
    it.inv = (ta == 2'b11) || (tb == 2'b11);
    total = int'(ta) + int'(tb) + int'(tc);
    it.sum  = it.inv ? 2'd0 : 2'(total % 3);
    it.cout = it.inv ? 1'b0 : (total >= 3);
    exp_q.push_back(it);
  endtask

  // monitor: results are due in the same cycle (R10), sampled at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        item_t e;
        e = exp_q.pop_front();
        check("R7 invalid", int'(inv), int'(e.inv));
        check("R9 sum code legal", int'(sum == 2'b11), 0);
        if (e.inv) begin
          check("R8 sum cleared", int'(sum), 0);
          check("R8 carry cleared", int'(cout), 0);
        end else begin
          check(e.cin ? "R4 sum" : "R3 sum", int'(sum), int'(e.sum));
          check(e.cin ? "R6 carry" : "R5 carry", int'(cout), int'(e.cout));
          check("R2 identity", 3 * int'(cout) + int'(sum),
                int'(e.a) + int'(e.b) + int'(e.cin));
        end
      end
    end
  end

  initial begin
    a = 2'd0; b = 2'd0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: zero operands give a zero digit and no carry
    check("R1 reset sum", int'(sum), 0);
    check("R1 reset carry", int'(cout), 0);
    check("R1 reset invalid", int'(inv), 0);
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          drive(2'(i), 2'(j), c[0]);
    // boundary: maximal carry chain input, then illegal on each side
    drive(2'd2, 2'd2, 1'b1);
    drive(2'd3, 2'd2, 1'b1);
    drive(2'd2, 2'd3, 1'b0);
    drive(2'd0, 2'd0, 1'b1);
    // R10: change inputs mid-cycle, result must follow without an edge
    @(posedge clk);
    @(negedge clk);
    #1 a = 2'd1; b = 2'd1; cin = 1'b1;
    #1 check("R10 no-clock sum", int'(sum), 0);
    check("R10 no-clock carry", int'(cout), 1);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule